// File: doc/BRIEF.md
# Block Erase Scheduler With Suspend

This block is the erase side of a program/erase controller for a flash array that is split into equal blocks. Software asks for one or more blocks to be erased, or for the whole chip to be erased. The scheduler gathers block requests during a selection window that restarts with every new request. When the window closes, it takes out every block whose protection group is locked. It then erases the remaining blocks one at a time, from the lowest index upward. For each block it holds a request toward the array model until that model reports completion.

A block-erase run can be paused with a suspend pulse and continued later with a resume pulse. If the pause comes during the selection window, the window is frozen. On resume, erasing starts at once with the list that was already gathered, and no more blocks can be added. If the pause comes while a block is being erased, the block in progress is recorded and erased again from the start on resume. A chip-wide erase cannot be paused. A run in which every chosen block is protected shows busy for a fixed number of microseconds and then ends without any request reaching the array. All timing counts pulses of a one-cycle microsecond tick.

Top module: `erase_sched`

## Requirements
- R1: After reset the block is idle: `busy`, `suspended` and `erase_req` are all 0.
- R2: Erasing begins on the clock edge after the SEL_WIN_US-th `us_tick` pulse that follows the most recent accepted selection. A new selection made inside the window sets the count back to zero. While the window is open, `busy` is 1 and `erase_req` is 0.
- R3: A selection made while erasing, while suspended or during a protected no-op run has no effect on which blocks get erased.
- R4: Blocks are erased one at a time in ascending index order. `erase_req` stays high with a stable `erase_blk` until `erase_done` is seen. One cycle after the last block's `erase_done`, `busy` is 0.
- R5: Block i belongs to protection group i/GRP_SIZE, so with the defaults blocks 4g..4g+3 form group g. Setting bit g of `prot_grp` makes the scheduler skip those blocks without raising any error.
- R6: If every block in a run is protected, `busy` stays 1 with `erase_req` at 0 for NOOP_US ticks. It falls to 0 on the edge after the NOOP_US-th tick.
- R7: A suspend pulse during a block erase sets `suspended` to 1 and clears `erase_req` and `busy` on the next cycle. A later resume pulse raises `erase_req` again on the next cycle, with the same `erase_blk`, so that block is erased again from the start.
- R8: A suspend pulse during the selection window takes effect on the next cycle, and no tick expires the window while suspended. On resume, erasing of the blocks already gathered starts on the next cycle.
- R9: `chip_erase` pulsed while idle erases every unprotected block in ascending order, with no window. Suspend pulses have no effect during a chip erase.
- R10: Suspend and resume can be repeated any number of times during one block erase. Each resume restarts the same block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| sel_valid | input | 1 | Pulse: add `sel_blk` to the erase list |
| sel_blk | input | 4 | Index of the block being selected |
| chip_erase | input | 1 | Pulse: erase every unprotected block |
| suspend | input | 1 | Pulse: pause a block-erase run |
| resume | input | 1 | Pulse: continue a paused run |
| prot_grp | input | 4 | One lock bit per group of GRP_SIZE blocks |
| erase_done | input | 1 | Array model reports that the requested block is erased |
| busy | output | 1 | Window open, erasing or no-op run in progress |
| suspended | output | 1 | Run paused |
| erase_req | output | 1 | Erase request to the array |
| erase_blk | output | 4 | Block currently being erased |

## Verification
Every pulse on a command input changes the state on the edge that samples it. Its result (`erase_req`, `erase_blk`, `suspended`, `busy`) is therefore due in the next cycle. The two timers are the exception. A tick that brings a timer to its limit makes the state change one edge later, so the window and no-op results are due two edges after that tick. The bench drives every input on a falling edge and holds it for one full cycle. It reads the outputs on the next falling edge, or one falling edge later for the timer cases, and confirms that an output has not yet changed one falling edge before it is due.

// File: rtl/es_pkg.sv
// Shared types for the block erase scheduler.
package es_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SELECT = 3'd1,
        ST_ERASE  = 3'd2,
        ST_NOOP   = 3'd3,
        ST_SUSP   = 3'd4
    } es_state_t;
endpackage

// File: rtl/es_tick_timer.sv
// Counts microsecond tick pulses up to LIMIT and then holds there.
// Assumes: tick lasts one cycle; clr has priority over counting.
module es_tick_timer #(
    parameter int LIMIT = 50,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic expired
);
    logic [W-1:0] cnt;

    // Count ticks while running; restart from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && tick && cnt != W'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    // Timer has reached its limit.
    always_comb expired = (cnt == W'(LIMIT));

    // The count never passes the limit (window/no-op timing, R2).
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(LIMIT));
endmodule

// File: rtl/es_prot_map.sv
// Expands the per-group lock bits into a per-block protection vector.
// Assumes: groups are GRP_SIZE consecutive blocks, group g starting at g*GRP_SIZE.
module es_prot_map #(
    parameter int NUM_BLK  = 16,
    parameter int GRP_SIZE = 4,
    localparam int NUM_GRP = NUM_BLK / GRP_SIZE
) (
    input  logic [NUM_GRP-1:0] grp_lock,
    output logic [NUM_BLK-1:0] blk_lock
);
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        // Each block takes the lock bit of its group.
        assign blk_lock[b] = grp_lock[b / GRP_SIZE];
    end
endmodule

// File: rtl/es_lowest_pick.sv
// Finds the lowest set bit of a vector, which sets the ascending erase order.
// Assumes: idx is meaningful only when any is 1.
module es_lowest_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/erase_sched.sv
// Block erase scheduler: gathers block selections inside a restartable window,
// removes protected blocks, erases the rest in ascending order through a
// request/done handshake, and supports suspend/resume of block-erase runs.
// Assumes: command inputs are one-cycle pulses; erase_done is honoured only
// while erase_req is high; protection is sampled when a run starts.
module erase_sched
    import es_pkg::*;
#(
    parameter int NUM_BLK    = 16,
    parameter int GRP_SIZE   = 4,
    parameter int SEL_WIN_US = 50,
    parameter int NOOP_US    = 100,
    localparam int BLK_W   = $clog2(NUM_BLK),
    localparam int NUM_GRP = NUM_BLK / GRP_SIZE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               us_tick,
    input  logic               sel_valid,
    input  logic [BLK_W-1:0]   sel_blk,
    input  logic               chip_erase,
    input  logic               suspend,
    input  logic               resume,
    input  logic [NUM_GRP-1:0] prot_grp,
    input  logic               erase_done,
    output logic               busy,
    output logic               suspended,
    output logic               erase_req,
    output logic [BLK_W-1:0]   erase_blk
);
    es_state_t          state, state_n;
    logic [NUM_BLK-1:0] pend, pend_n;
    logic [NUM_BLK-1:0] work, work_n;
    logic               chip_run, chip_run_n;
    logic               win_susp, win_susp_n;

    logic [NUM_BLK-1:0] blk_lock;
    logic [NUM_BLK-1:0] sel_bit, cur_bit, remain, pend_ok, chip_ok;
    logic [BLK_W-1:0]   cur_idx;
    logic               cur_any;
    logic               win_exp, noop_exp;

    es_prot_map #(.NUM_BLK(NUM_BLK), .GRP_SIZE(GRP_SIZE)) i_prot (
        .grp_lock (prot_grp),
        .blk_lock (blk_lock)
    );

    es_lowest_pick #(.N(NUM_BLK), .IW(BLK_W)) i_pick (
        .vec (work),
        .idx (cur_idx),
        .any (cur_any)
    );

    es_tick_timer #(.LIMIT(SEL_WIN_US)) i_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     ((state != ST_SELECT) || sel_valid),
        .run     (state == ST_SELECT),
        .tick    (us_tick),
        .expired (win_exp)
    );

    es_tick_timer #(.LIMIT(NOOP_US)) i_noop (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != ST_NOOP),
        .run     (state == ST_NOOP),
        .tick    (us_tick),
        .expired (noop_exp)
    );

    // Masks used when a run starts or a block finishes.
    always_comb begin
        sel_bit = NUM_BLK'(1) << sel_blk;
        cur_bit = NUM_BLK'(1) << cur_idx;
        remain  = work & ~cur_bit;
        pend_ok = pend & ~blk_lock;
        chip_ok = ~blk_lock;
    end

    // Next-state logic for the scheduler.
    always_comb begin
        state_n    = state;
        pend_n     = pend;
        work_n     = work;
        chip_run_n = chip_run;
        win_susp_n = win_susp;
        unique case (state)
            ST_IDLE: begin
                if (chip_erase) begin
                    work_n     = chip_ok;
                    chip_run_n = 1'b1;
                    pend_n     = '0;
                    state_n    = (|chip_ok) ? ST_ERASE : ST_NOOP;
                end else if (sel_valid) begin
                    pend_n  = sel_bit;
                    state_n = ST_SELECT;
                end
            end
            ST_SELECT: begin
                if (suspend) begin
                    win_susp_n = 1'b1;
                    state_n    = ST_SUSP;
                end else if (sel_valid) begin
                    pend_n = pend | sel_bit;
                end else if (win_exp) begin
                    work_n  = pend_ok;
                    state_n = (|pend_ok) ? ST_ERASE : ST_NOOP;
                end
            end
            ST_ERASE: begin
                if (erase_done) begin
                    work_n = remain;
                    if (remain == '0) begin
                        chip_run_n = 1'b0;
                        state_n    = ST_IDLE;
                    end else if (suspend && !chip_run) begin
                        win_susp_n = 1'b0;
                        state_n    = ST_SUSP;
                    end
                end else if (suspend && !chip_run) begin
                    win_susp_n = 1'b0;
                    state_n    = ST_SUSP;
                end
            end
            ST_NOOP: begin
                if (noop_exp) begin
                    chip_run_n = 1'b0;
                    state_n    = ST_IDLE;
                end
            end
            ST_SUSP: begin
                if (resume) begin
                    win_susp_n = 1'b0;
                    if (win_susp) begin
                        work_n  = pend_ok;
                        state_n = (|pend_ok) ? ST_ERASE : ST_NOOP;
                    end else begin
                        state_n = ST_ERASE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend     <= '0;
            work     <= '0;
            chip_run <= 1'b0;
            win_susp <= 1'b0;
        end else begin
            state    <= state_n;
            pend     <= pend_n;
            work     <= work_n;
            chip_run <= chip_run_n;
            win_susp <= win_susp_n;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy      = (state == ST_SELECT) || (state == ST_ERASE) || (state == ST_NOOP);
        suspended = (state == ST_SUSP);
        erase_req = (state == ST_ERASE) && cur_any;
        erase_blk = cur_idx;
    end

    // A pending request holds its block until done or suspend (R4).
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done && !suspend) |=> (erase_req && $stable(erase_blk)));

    // The next block requested after a done is always higher (R4).
    p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_done) |=> (!erase_req || erase_blk > $past(erase_blk)));

    // Suspend during a block-erase run is in effect one cycle later (R7).
    p_susp_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && suspend && !chip_run && !erase_done) |=> (suspended && !erase_req));

    // A chip-wide erase ignores suspend (R9).
    p_chip_nosusp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && chip_run && suspend) |=> !suspended);

    // Resume after an erase-time suspend requests the same block again (R7).
    p_resume_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && resume && !win_susp) |=> (erase_req && erase_blk == $past(erase_blk)));
endmodule

// File: tb/test_erase_sched.sv
module test_erase_sched;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 5;
    localparam int NOOP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       sel_valid = 1'b0;
    logic [3:0] sel_blk = '0;
    logic       chip_erase = 1'b0;
    logic       suspend = 1'b0;
    logic       resume = 1'b0;
    logic [3:0] prot_grp = '0;
    logic       erase_done = 1'b0;
    logic       busy, suspended, erase_req;
    logic [3:0] erase_blk;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    erase_sched #(.NUM_BLK(16), .GRP_SIZE(4), .SEL_WIN_US(WIN), .NOOP_US(NOOP)) i_erase_sched (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sel_valid(sel_valid),
        .sel_blk(sel_blk), .chip_erase(chip_erase), .suspend(suspend),
        .resume(resume), .prot_grp(prot_grp), .erase_done(erase_done),
        .busy(busy), .suspended(suspended), .erase_req(erase_req), .erase_blk(erase_blk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_sel(input int b);
        @(negedge clk); sel_valid = 1'b1; sel_blk = 4'(b);
        @(negedge clk); sel_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic pulse_susp();
        @(negedge clk); suspend = 1'b1;
        @(negedge clk); suspend = 1'b0;
    endtask

    task automatic pulse_res();
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
    endtask

    task automatic pulse_chip();
        @(negedge clk); chip_erase = 1'b1;
        @(negedge clk); chip_erase = 1'b0;
    endtask

    // Expect a request for block b, then report it done.
    task automatic finish_blk(input string tag, input int b);
        chk({tag, " req"}, int'(erase_req), 1);
        chk({tag, " blk"}, int'(erase_blk), b);
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 suspended", int'(suspended), 0);
        chk("R1 req", int'(erase_req), 0);
    endtask

    // R2 window restart, R3 selection ignored while erasing, R4 order.
    task automatic t_window();
        pulse_sel(7);
        ticks(3);
        pulse_sel(2);
        ticks(WIN - 1);
        chk("R2 window still open busy", int'(busy), 1);
        chk("R2 window restarted", int'(erase_req), 0);
        ticks(1);
        chk("R2 not before next edge", int'(erase_req), 0);
        @(negedge clk);
        finish_blk("R4 first lowest", 2);
        pulse_sel(9);
        finish_blk("R4 second", 7);
        chk("R3 late select ignored, idle", int'(busy), 0);
    endtask

    // R5 protected group skipped silently.
    task automatic t_prot();
        prot_grp = 4'b0010;
        pulse_sel(5);
        pulse_sel(8);
        pulse_sel(3);
        ticks(WIN);
        @(negedge clk);
        finish_blk("R5 unprotected 3", 3);
        finish_blk("R5 skip 5 go to 8", 8);
        chk("R5 done", int'(busy), 0);
        prot_grp = 4'b0000;
    endtask

    // R6 every selected block protected.
    task automatic t_allprot();
        prot_grp = 4'b0001;
        pulse_sel(1);
        pulse_sel(2);
        ticks(WIN);
        @(negedge clk);
        chk("R6 busy in noop", int'(busy), 1);
        chk("R6 no request", int'(erase_req), 0);
        ticks(NOOP - 1);
        chk("R6 still busy", int'(busy), 1);
        ticks(1);
        chk("R6 busy until next edge", int'(busy), 1);
        chk("R6 no request late", int'(erase_req), 0);
        @(negedge clk);
        chk("R6 idle after noop", int'(busy), 0);
        prot_grp = 4'b0000;
    endtask

    // R7 suspend during erase, R10 repeated, R3 select while suspended.
    task automatic t_susp_erase();
        pulse_sel(10);
        ticks(WIN);
        @(negedge clk);
        chk("R7 erasing 10", int'(erase_blk), 10);
        pulse_susp();
        chk("R7 suspended", int'(suspended), 1);
        chk("R7 req dropped", int'(erase_req), 0);
        chk("R7 not busy", int'(busy), 0);
        pulse_sel(11);
        pulse_res();
        chk("R7 resume req", int'(erase_req), 1);
        chk("R7 resume same blk", int'(erase_blk), 10);
        pulse_susp();
        chk("R10 second suspend", int'(suspended), 1);
        pulse_res();
        chk("R10 second resume same blk", int'(erase_blk), 10);
        chk("R10 second resume req", int'(suspended), 0);
        finish_blk("R7 finish 10", 10);
        chk("R3 block 11 never added", int'(busy), 0);
    endtask

    // R8 suspend during the selection window.
    task automatic t_susp_window();
        pulse_sel(12);
        ticks(2);
        pulse_susp();
        chk("R8 suspended at once", int'(suspended), 1);
        ticks(WIN + 1);
        chk("R8 window frozen", int'(erase_req), 0);
        chk("R8 still suspended", int'(suspended), 1);
        pulse_sel(13);
        pulse_res();
        chk("R8 erase starts on resume", int'(erase_req), 1);
        finish_blk("R8 gathered block", 12);
        chk("R8 block 13 not added", int'(busy), 0);
    endtask

    // R9 chip erase skips protected groups and ignores suspend.
    task automatic t_chip();
        prot_grp = 4'b1110;
        pulse_chip();
        chk("R9 starts without window", int'(erase_req), 1);
        pulse_susp();
        chk("R9 suspend ignored", int'(suspended), 0);
        chk("R9 still requesting", int'(erase_req), 1);
        for (int b = 0; b < 4; b++) finish_blk("R9 chip block", b);
        chk("R9 idle after group 0", int'(busy), 0);
        prot_grp = 4'b0000;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_prot();
        t_allprot();
        t_susp_erase();
        t_susp_window();
        t_chip();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule